// File: doc/BRIEF.md
# IDE Channel Address Decoder

This block sits in front of a two-channel IDE controller and decodes every host I/O access. It holds five base registers: a command window and a control window for each channel, and one bus-master window. Each window has a size fixed by a parameter. For every access it reports one of two things one clock later. Either the target (window kind, channel, offset inside the window, device index and number of 16-bit beats) or a one-cycle error pulse.

The block also watches writes to the device/head register of each command window. It keeps one drive-select bit per channel, so an access can be steered to the master or slave device on that channel. The bus-master window is shared by both channels and is split by offset. A parameter mask states which of the four device positions are populated. Accesses to an empty position are turned into zero-reads or dropped writes. A global I/O enable input lets accesses complete with no effect at all.

Top module: `ide_chan_decoder`

## Requirements
- R1: After reset every decode output, the error output and both drive-select bits are 0, and the five bases hold their `BASE_RESET` values.
- R2: Windows are tried in the fixed order primary command (index 0), primary control (1), secondary command (2), secondary control (3), bus-master (4), and the first window with base <= address < base+size wins. A hit reports kind 1 for command, 2 for control and 3 for bus-master, and gives the channel (0 primary, 1 secondary) and the offset address-base.
- R3: An enabled access whose address lies in no window raises `dec_err` and no hit.
- R4: In the bus-master window, offsets below `BM_CH1_OFS` report channel 0 and all other offsets report channel 1.
- R5: A base write with value 0 leaves that window's base unchanged, and a nonzero value replaces it for the next access.
- R6: A legal 1-byte write to command-window offset `SEL_OFS` (6) sets that channel's drive bit to bit `SEL_BIT` (4) of the data. The new bit already steers that same write. No other access changes a drive bit.
- R7: The device index is 2*channel + drive bit of that channel.
- R8: The command-window data register (offset 0) accepts 2- or 4-byte accesses. A 4-byte access reports 2 beats and every other legal access reports 1.
- R9: Other command and control registers accept only 1-byte accesses, and the bus-master window accepts 1, 2 or 4 bytes. Any other size raises `dec_err` and gives no hit.
- R10: A hit in a command or control window asserts `dev_go` only when `DEV_PRESENT[device]` is 1. A read of an absent device asserts `rd_zero` instead, and a write to an absent device asserts neither.
- R11: With `io_en` low an access raises neither hit nor error, still completes (`acc_done`) and leaves the drive bits unchanged.
- R12: All results appear exactly one cycle after `req_valid`, and `dec_err` is high only in the cycle after an erroring access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_en | input | 1 | I/O space decode enable |
| cfg_we | input | 1 | Base register write strobe |
| cfg_idx | input | 3 | Window index for the base write (0..4) |
| cfg_base | input | AW | New base value (0 is ignored) |
| req_valid | input | 1 | Access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 8 | Low byte of write data |
| acc_done | output | 1 | Access completed |
| dec_hit | output | 1 | Legal decoded access |
| dec_kind | output | 2 | 0 none, 1 command, 2 control, 3 bus-master |
| dec_chan | output | 1 | Channel |
| dec_offset | output | OW | Offset within window |
| dev_idx | output | 2 | Target device index |
| dev_go | output | 1 | Forward to present device |
| dec_beats | output | 2 | Number of 16-bit device beats |
| rd_zero | output | 1 | Read of absent device returns zero |
| dec_err | output | 1 | Unmapped address or illegal size |
| drive_sel | output | 2 | Drive-select bit per channel |

## Verification
The hardest case to reach is a conflict between windows. With the reset bases no two windows overlap, so priority never shows. The stimulus moves the primary control base onto the secondary command range and checks that the earlier window wins. It also checks that the old range now errors. A base write of zero has to be checked the same way, through a hit at the unchanged address. A read of the one absent device needs the secondary drive bit set first, so a full address/size sweep is run once with both drive bits clear and once with both set through select writes.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
   localparam int NWIN = 5;
   localparam int WIN_BM = 4;

   typedef enum logic [1:0] {
      WK_NONE = 2'd0,
      WK_CMD  = 2'd1,
      WK_CTL  = 2'd2,
      WK_BM   = 2'd3
   } win_kind_e;
endpackage

// File: rtl/ide_win_bank.sv
module ide_win_bank
   import ide_dec_pkg::*;
#(
   parameter int AW = 16,
   parameter int OW = 4,
   parameter int CMD_SIZE = 8,
   parameter int CTL_SIZE = 4,
   parameter int BM_SIZE = 16,
   parameter logic [NWIN*AW-1:0] BASE_RESET = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [2:0]    cfg_idx,
   input  logic [AW-1:0] cfg_base,
   input  logic [AW-1:0] addr,
   output logic          hit_any,
   output logic [2:0]    hit_sel,
   output logic [OW-1:0] hit_ofs
);
   logic [NWIN-1:0] hit;
   logic [OW-1:0]   ofs [NWIN];

   for (genvar i = 0; i < NWIN; i++) begin : g_win
      localparam int SZ = (i == WIN_BM) ? BM_SIZE : ((i % 2 == 0) ? CMD_SIZE : CTL_SIZE);
      logic [AW-1:0] base_q;
      logic [AW-1:0] diff;

      always_ff @(posedge clk) begin
         if (!rst_n)
            base_q <= BASE_RESET[i*AW +: AW];
         else if (cfg_we && (cfg_idx == 3'(i)) && (cfg_base != '0))
            base_q <= cfg_base;
      end

      assign diff   = addr - base_q;
      assign hit[i] = (addr >= base_q) &&
                      ({1'b0, addr} < ({1'b0, base_q} + (AW+1)'(SZ)));
      assign ofs[i] = diff[OW-1:0];
   end

   always_comb begin
      hit_any = 1'b0;
      hit_sel = '0;
      hit_ofs = '0;
      for (int i = NWIN-1; i >= 0; i--) begin
         if (hit[i]) begin
            hit_any = 1'b1;
            hit_sel = 3'(i);
            hit_ofs = ofs[i];
         end
      end
   end
endmodule

// File: rtl/ide_size_chk.sv
module ide_size_chk
   import ide_dec_pkg::*;
#(
   parameter int OW = 4,
   parameter int DATA_OFS = 0
) (
   input  win_kind_e     kind,
   input  logic [OW-1:0] ofs,
   input  logic [2:0]    size,
   output logic          size_ok,
   output logic [1:0]    beats
);
   localparam logic [OW-1:0] DOFS = OW'(DATA_OFS);
   logic is_data;

   assign is_data = (kind == WK_CMD) && (ofs == DOFS);

   always_comb begin
      unique case (kind)
         WK_BM:          size_ok = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
         WK_CMD, WK_CTL: size_ok = is_data ? ((size == 3'd2) || (size == 3'd4))
                                           : (size == 3'd1);
         default:        size_ok = 1'b0;
      endcase
      beats = (is_data && size == 3'd4) ? 2'd2 : 2'd1;
   end
endmodule

// File: rtl/ide_drive_snoop.sv
module ide_drive_snoop #(
   parameter int NCH = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           upd,
   input  logic           upd_chan,
   input  logic           upd_val,
   output logic [NCH-1:0] drive_q,
   output logic [NCH-1:0] drive_nx
);
   always_comb begin
      drive_nx = drive_q;
      if (upd) drive_nx[upd_chan] = upd_val;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) drive_q <= '0;
      else        drive_q <= drive_nx;
   end
endmodule

// File: rtl/ide_chan_decoder.sv
module ide_chan_decoder
   import ide_dec_pkg::*;
#(
   parameter int AW = 16,
   parameter int CMD_SIZE = 8,
   parameter int CTL_SIZE = 4,
   parameter int BM_SIZE = 16,
   parameter int BM_CH1_OFS = 8,
   parameter int SEL_OFS = 6,
   parameter int SEL_BIT = 4,
   parameter int DATA_OFS = 0,
   parameter logic [3:0] DEV_PRESENT = 4'b1111,
   parameter logic [NWIN*AW-1:0] BASE_RESET =
      {16'hC000, 16'h0374, 16'h0170, 16'h03F4, 16'h01F0},
   localparam int MAXSZ = (BM_SIZE > CMD_SIZE) ?
      ((BM_SIZE > CTL_SIZE) ? BM_SIZE : CTL_SIZE) :
      ((CMD_SIZE > CTL_SIZE) ? CMD_SIZE : CTL_SIZE),
   localparam int OW = (MAXSZ > 1) ? $clog2(MAXSZ) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          io_en,
   input  logic          cfg_we,
   input  logic [2:0]    cfg_idx,
   input  logic [AW-1:0] cfg_base,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [2:0]    req_size,
   input  logic [7:0]    req_wdata,
   output logic          acc_done,
   output logic          dec_hit,
   output logic [1:0]    dec_kind,
   output logic          dec_chan,
   output logic [OW-1:0] dec_offset,
   output logic [1:0]    dev_idx,
   output logic          dev_go,
   output logic [1:0]    dec_beats,
   output logic          rd_zero,
   output logic          dec_err,
   output logic [1:0]    drive_sel
);
   localparam logic [OW-1:0] CH1_OFS = OW'(BM_CH1_OFS);
   localparam logic [OW-1:0] SOFS    = OW'(SEL_OFS);

   if (BM_CH1_OFS >= BM_SIZE) begin : g_bad_split
      $error("BM_CH1_OFS must lie inside the bus-master window");
   end
   if (SEL_OFS >= CMD_SIZE || DATA_OFS >= CMD_SIZE) begin : g_bad_ofs
      $error("select and data offsets must lie inside the command window");
   end
   if (SEL_BIT > 7) begin : g_bad_bit
      $error("SEL_BIT must address a bit of the low data byte");
   end
   if (MAXSZ >= (1 << AW)) begin : g_bad_aw
      $error("window sizes exceed the address space");
   end

   logic          hit_any;
   logic [2:0]    hit_sel;
   logic [OW-1:0] hit_ofs;
   win_kind_e     kind;
   logic          chan;
   logic          size_ok;
   logic [1:0]    beats;
   logic          legal;
   logic          sel_wr;
   logic [1:0]    drive_nx;
   logic [1:0]    dev;
   logic          present;
   logic          to_dev;
   logic          err_d;

   ide_win_bank #(
      .AW(AW), .OW(OW), .CMD_SIZE(CMD_SIZE), .CTL_SIZE(CTL_SIZE),
      .BM_SIZE(BM_SIZE), .BASE_RESET(BASE_RESET)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_base(cfg_base), .addr(req_addr), .hit_any(hit_any),
      .hit_sel(hit_sel), .hit_ofs(hit_ofs)
   );

   always_comb begin
      if (!hit_any)                 kind = WK_NONE;
      else if (hit_sel == 3'(WIN_BM)) kind = WK_BM;
      else if (hit_sel[0])          kind = WK_CTL;
      else                          kind = WK_CMD;
      chan = (kind == WK_BM) ? (hit_ofs >= CH1_OFS) : hit_sel[1];
   end

   ide_size_chk #(.OW(OW), .DATA_OFS(DATA_OFS)) u_size (
      .kind(kind), .ofs(hit_ofs), .size(req_size),
      .size_ok(size_ok), .beats(beats)
   );

   assign legal  = req_valid && io_en && hit_any && size_ok;
   assign sel_wr = legal && req_write && (kind == WK_CMD) && (hit_ofs == SOFS);
   assign err_d  = req_valid && io_en && !(hit_any && size_ok);

   ide_drive_snoop #(.NCH(2)) u_snoop (
      .clk(clk), .rst_n(rst_n), .upd(sel_wr), .upd_chan(chan),
      .upd_val(req_wdata[SEL_BIT]), .drive_q(drive_sel), .drive_nx(drive_nx)
   );

   assign dev     = {chan, drive_nx[chan]};
   assign present = DEV_PRESENT[dev];
   assign to_dev  = legal && (kind != WK_BM);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_done   <= 1'b0;
         dec_hit    <= 1'b0;
         dec_kind   <= 2'd0;
         dec_chan   <= 1'b0;
         dec_offset <= '0;
         dev_idx    <= 2'd0;
         dev_go     <= 1'b0;
         dec_beats  <= 2'd0;
         rd_zero    <= 1'b0;
         dec_err    <= 1'b0;
      end else begin
         acc_done   <= req_valid;
         dec_hit    <= legal;
         dec_kind   <= legal ? 2'(kind) : 2'd0;
         dec_chan   <= legal ? chan : 1'b0;
         dec_offset <= legal ? hit_ofs : '0;
         dev_idx    <= legal ? dev : 2'd0;
         dev_go     <= to_dev && present;
         dec_beats  <= legal ? beats : 2'd0;
         rd_zero    <= to_dev && !present && !req_write;
         dec_err    <= err_d;
      end
   end
endmodule

// File: rtl/ide_chan_decoder_chk.sv
module ide_chan_decoder_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       io_en,
   input logic       req_valid,
   input logic       req_write,
   input logic       acc_done,
   input logic       dec_hit,
   input logic [1:0] dec_kind,
   input logic       dev_go,
   input logic [1:0] dec_beats,
   input logic       rd_zero,
   input logic       dec_err,
   input logic [1:0] drive_sel
);
   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> acc_done); // R12
   AST_ERR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !dec_err); // R12
   AST_IO_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !io_en) |=> (!dec_hit && !dec_err)); // R11
   AST_IO_OFF_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !io_en |=> $stable(drive_sel)); // R11
   AST_DRIVE_WR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_write) |=> $stable(drive_sel)); // R6
   AST_HIT_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(dec_hit && dec_err)); // R3
   AST_GO_DEV_WIN: assert property (@(posedge clk) disable iff (!rst_n)
      dev_go |-> (dec_hit && dec_kind != 2'd3)); // R10
   AST_RDZERO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      rd_zero |-> (dec_hit && !dev_go)); // R10
   AST_TWO_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_beats == 2'd2) |-> (dec_hit && dec_kind == 2'd1)); // R8
endmodule

bind ide_chan_decoder ide_chan_decoder_chk u_chk (.*);

// File: tb/sim_ide_chan_decoder.sv
module sim_ide_chan_decoder;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 10;
   localparam logic [3:0] PRES = 4'b0111;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          io_en = 1'b1;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_idx = '0;
   logic [AW-1:0] cfg_base = '0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [2:0]    req_size = '0;
   logic [7:0]    req_wdata = '0;
   logic          acc_done, dec_hit, dec_chan, dev_go, rd_zero, dec_err;
   logic [1:0]    dec_kind, dev_idx, dec_beats, drive_sel;
   logic [3:0]    dec_offset;

   int n_tests = 0;
   int n_fail = 0;
   bit done = 0;

   logic [AW-1:0] mb [5];
   int            msz [5];
   logic [1:0]    mdrv;

   always #(CLK_PERIOD/2) clk = ~clk;

   ide_chan_decoder #(
      .AW(AW), .CMD_SIZE(8), .CTL_SIZE(4), .BM_SIZE(16), .BM_CH1_OFS(8),
      .DEV_PRESENT(PRES),
      .BASE_RESET({10'h200, 10'h374, 10'h170, 10'h3F4, 10'h1F0})
   ) u0 (.*);

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg(input int idx, input logic [AW-1:0] b);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_base = b;
      @(negedge clk);
      cfg_we = 1'b0;
      if (b != '0) mb[idx] = b;
   endtask

   task automatic acc(input logic [AW-1:0] a, input int sz, input bit wr,
                      input logic [7:0] wd, input string tag_in);
      int w; bit ok, hit, errx, ch, go, rdz;
      int kind; logic [AW-1:0] off; logic [1:0] dev, bts;
      logic [17:0] e, act; string tag;
      w = -1;
      for (int i = 4; i >= 0; i--)
         if (a >= mb[i] && ({1'b0, a} < {1'b0, mb[i]} + 11'(msz[i]))) w = i;
      ok = 0; kind = 0; ch = 0; off = '0;
      if (w >= 0) begin
         off  = a - mb[w];
         kind = (w == 4) ? 3 : ((w % 2 == 1) ? 2 : 1);
         ch   = (w == 4) ? (off >= 8) : (w >= 2);
         if (kind == 3)                ok = (sz == 1 || sz == 2 || sz == 4);
         else if (kind == 1 && off == 0) ok = (sz == 2 || sz == 4);
         else                          ok = (sz == 1);
      end
      hit  = io_en && w >= 0 && ok;
      errx = io_en && !(w >= 0 && ok);
      if (hit && wr && kind == 1 && off == 6) mdrv[ch] = wd[4];
      dev  = {ch, mdrv[ch]};
      go   = hit && kind != 3 && PRES[dev];
      rdz  = hit && kind != 3 && !PRES[dev] && !wr;
      bts  = hit ? ((kind == 1 && off == 0 && sz == 4) ? 2'd2 : 2'd1) : 2'd0;
      if (!hit) begin kind = 0; ch = 0; off = '0; dev = 2'd0; end
      e = {1'b1, mdrv, hit, 2'(kind), ch, off[3:0], dev, go, bts, rdz, errx};
      if (tag_in != "")    tag = tag_in;
      else if (errx)       tag = (w >= 0) ? "R9" : "R3";
      else if (kind == 3)  tag = "R4";
      else if (bts == 2)   tag = "R8";
      else if (rdz)        tag = "R10";
      else                 tag = "R2/R7";
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a;
      req_size = 3'(sz); req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      act = {acc_done, drive_sel, dec_hit, dec_kind, dec_chan, dec_offset,
             dev_idx, dev_go, dec_beats, rd_zero, dec_err};
      check(act == e, tag, 32'(act), 32'(e));
   endtask

   task automatic sweep();
      for (int a = 0; a < (1 << AW); a++)
         for (int s = 1; s <= 4; s++)
            acc(AW'(a), s, 1'b0, 8'h00, "");
   endtask

   initial begin
      mb[0] = 10'h1F0; mb[1] = 10'h3F4; mb[2] = 10'h170; mb[3] = 10'h374; mb[4] = 10'h200;
      msz[0] = 8; msz[1] = 4; msz[2] = 8; msz[3] = 4; msz[4] = 16;
      mdrv = 2'b00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check({acc_done, dec_hit, dec_kind, dec_chan, dec_offset, dev_idx, dev_go,
             dec_beats, rd_zero, dec_err, drive_sel} == '0, "R1",
            32'({dec_hit, dec_err, drive_sel}), 32'h0);
      acc(10'h1F0, 2, 1'b0, 8'h00, "R1");
      // full sweep, drive bits clear
      sweep();
      // R6/R7: select writes, new bit steers the same write
      acc(10'h1F6, 1, 1'b1, 8'h10, "R6");
      check(drive_sel == 2'b01 && dev_idx == 2'd1, "R7", 32'({drive_sel, dev_idx}), 32'h5);
      acc(10'h176, 1, 1'b1, 8'hEF, "R6");
      acc(10'h176, 1, 1'b1, 8'h10, "R6");
      check(dev_idx == 2'd3 && !dev_go, "R10", 32'({dev_idx, dev_go}), 32'h6);
      acc(10'h1F6, 2, 1'b1, 8'h00, "R6");
      check(drive_sel == 2'b11, "R6", 32'(drive_sel), 32'h3);
      // R10: write to absent device dropped
      acc(10'h171, 1, 1'b1, 8'h55, "R10");
      check(!dev_go && !rd_zero && dec_hit, "R10", 32'({dec_hit, dev_go, rd_zero}), 32'h4);
      // R12: error is a single pulse
      acc(10'h000, 1, 1'b0, 8'h00, "R3");
      @(negedge clk);
      check(!dec_err && !acc_done, "R12", 32'({dec_err, acc_done}), 32'h0);
      // sweep again with both drive bits set
      sweep();
      // R11: I/O disabled
      io_en = 1'b0;
      acc(10'h1F6, 1, 1'b1, 8'h00, "R11");
      acc(10'h000, 1, 1'b0, 8'h00, "R11");
      acc(10'h1F0, 3, 1'b0, 8'h00, "R11");
      check(drive_sel == 2'b11, "R11", 32'(drive_sel), 32'h3);
      io_en = 1'b1;
      // R5: zero base write ignored
      cfg(0, 10'h000);
      acc(10'h1F0, 2, 1'b0, 8'h00, "R5");
      acc(10'h000, 1, 1'b0, 8'h00, "R5");
      // R5/R2: move primary control over secondary command; priority
      cfg(1, 10'h170);
      acc(10'h170, 1, 1'b0, 8'h00, "R2");
      check(dec_kind == 2'd2 && dec_chan == 1'b0, "R2", 32'({dec_kind, dec_chan}), 32'h4);
      acc(10'h174, 1, 1'b0, 8'h00, "R2");
      acc(10'h3F4, 1, 1'b0, 8'h00, "R5");
      cfg(4, 10'h100);
      for (int o = 0; o < 16; o++) acc(10'h100 + AW'(o), 1, 1'b0, 8'h00, "R4");
      acc(10'h200, 1, 1'b0, 8'h00, "R5");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule